// File: doc/BRIEF.md
# Gate-Genome Netlist Evaluator

This block evaluates a small combinational network held as a list of two-input gate genes. Every gene carries a function code and two source indices into one flat value space. Index 0 is a fixed logic 0 and index 1 is a fixed logic 1. The next indices hold the bits of the two operands. The indices after those hold the node results, one index per node, in gene order. Software loads the genes and the output-selection list through two write ports. It then gives a node count and the two operands and pulses start. The block visits one node per clock, then collects the selected bits into the result register and pulses done.

A genome that breaks the rules is not evaluated into the result. This covers an unknown function code, a source index that is not below its node's own index, an output entry that names a slot that no node defines, and a node count larger than the gene memory. In that case the error flag is raised with done and the previous result stays in place.

Both configuration ports are valid/ready. A write lands on a clock edge where valid and ready are both high. Ready is high only while the block is idle and falls for the whole evaluation, so a sender must hold its write until ready returns. A write accepted in the same cycle as start takes effect for that evaluation. Start, done, the error flag and the result are plain pins.

Top module: `genome_eval`

## Requirements
- R1: Value index 0 reads as 0 and index 1 reads as 1, wherever that index is named (node source or output entry).
- R2: With operand widths W_A and W_B, index 2+i holds bit i of operand A (i from 0) and index 2+W_A+j holds bit j of operand B. Node n writes index 2+W_A+W_B+n.
- R3: Function codes: 0 copies source A; 1 is NOT A; 2 AND; 3 OR; 4 XOR; 5 NAND; 6 NOR; 7 XNOR; 8 gives 1; 9 gives 0.
- R4: Codes 0 and 1 ignore source B, and codes 8 and 9 ignore both sources. An ignored source never affects the value or the error flag, whatever index it holds.
- R5: A used source index equal to or above the node's own index makes the evaluation fail (error flag set, result kept).
- R6: Result bit k equals the value at the index held in output-list entry k, after all nodes in order have been evaluated.
- R7: The evaluation fails, with the error flag set and the result kept, when a function code above 9 is used, when an output entry is at or above 2+W_A+W_B+count, or when the count exceeds the gene memory depth. Done is still pulsed.
- R8: With start sampled at edge E and count n (treated as 0 when the count is too large), done is high for exactly one cycle, after edge E+n+1.
- R9: Start is accepted only when idle. Both ready outputs are low from the edge that accepts start until done, and a start or configuration write offered in that time has no effect.
- R10: After reset the result is 0, the error flag is 0, done is 0 and both ready outputs are 1. The result and the error flag change only at the edge where done rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gene_valid | input | 1 | Gene write offered |
| gene_ready | output | 1 | Gene write can be taken (idle) |
| gene_addr | input | 6 | Node number of the gene |
| gene_src_a | input | 7 | First source index |
| gene_src_b | input | 7 | Second source index |
| gene_fn | input | 4 | Function code |
| osel_valid | input | 1 | Output-list write offered |
| osel_ready | output | 1 | Output-list write can be taken (idle) |
| osel_addr | input | 4 | Result bit being configured |
| osel_idx | input | 7 | Value index feeding that result bit |
| node_count | input | 7 | Number of nodes to evaluate, sampled with start |
| start | input | 1 | Start pulse |
| opnd_a | input | 8 | Operand A, sampled with start |
| opnd_b | input | 8 | Operand B, sampled with start |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last evaluation failed |
| result | output | 16 | Gathered output bits |

## Verification
A genome with no nodes and an output list that selects only the constants, or only the operand bits, separates the value-space layout from the gate logic. A ten-node genome that uses every function code on one bit of each operand, driven through all four bit combinations, gives each gate's full truth table. Genomes that put out-of-range indices in ignored source fields tell ignored operands apart from used ones. A known two-bit adder genome, random legal genomes and single-fault variants of the adder (bad code, backward source, undefined output slot, oversized count) test the ordered evaluation against the error path.

// File: rtl/genome_pkg.sv
`timescale 1ns/1ps
package genome_pkg;
  localparam int IDX_W = 7;
  localparam int FN_W  = 4;

  localparam logic [FN_W-1:0] FN_PASS = 4'd0;
  localparam logic [FN_W-1:0] FN_INV  = 4'd1;
  localparam logic [FN_W-1:0] FN_AND  = 4'd2;
  localparam logic [FN_W-1:0] FN_OR   = 4'd3;
  localparam logic [FN_W-1:0] FN_XOR  = 4'd4;
  localparam logic [FN_W-1:0] FN_NAND = 4'd5;
  localparam logic [FN_W-1:0] FN_NOR  = 4'd6;
  localparam logic [FN_W-1:0] FN_XNOR = 4'd7;
  localparam logic [FN_W-1:0] FN_ONE  = 4'd8;
  localparam logic [FN_W-1:0] FN_ZERO = 4'd9;

  typedef struct packed {
    logic [IDX_W-1:0] src_a;
    logic [IDX_W-1:0] src_b;
    logic [FN_W-1:0]  fn;
  } gene_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_GATHER = 2'd2
  } eval_state_e;
endpackage

// File: rtl/genome_gene_store.sv
`timescale 1ns/1ps
module genome_gene_store
  import genome_pkg::*;
#(
  parameter int NODES = 64,
  parameter int AW    = $clog2(NODES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  gene_t         wdata,
  input  logic [AW-1:0] raddr,
  output gene_t         rdata
);
  gene_t mem [NODES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NODES; i++) mem[i] <= '0;
    end else if (we && (32'(waddr) < NODES)) begin
      mem[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (32'(raddr) < NODES) rdata = mem[raddr];
  end
endmodule

// File: rtl/genome_outsel_store.sv
`timescale 1ns/1ps
module genome_outsel_store
  import genome_pkg::*;
#(
  parameter int N_OUT = 16,
  parameter int AW    = $clog2(N_OUT)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [AW-1:0]               waddr,
  input  logic [IDX_W-1:0]            widx,
  output logic [N_OUT-1:0][IDX_W-1:0] sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= '0;
    end else if (we && (32'(waddr) < N_OUT)) begin
      sel[waddr] <= widx;
    end
  end
endmodule

// File: rtl/genome_node_alu.sv
`timescale 1ns/1ps
module genome_node_alu
  import genome_pkg::*;
(
  input  logic [FN_W-1:0]  fn,
  input  logic [IDX_W-1:0] src_a,
  input  logic [IDX_W-1:0] src_b,
  input  logic [IDX_W-1:0] own_idx,
  input  logic             a_bit,
  input  logic             b_bit,
  output logic             y,
  output logic             bad
);
  logic uses_a, uses_b, code_bad;

  always_comb begin
    uses_a   = (fn <= FN_XNOR);
    uses_b   = (fn >= FN_AND) && (fn <= FN_XNOR);
    code_bad = (fn > FN_ZERO);
    case (fn)
      FN_PASS: y = a_bit;
      FN_INV:  y = ~a_bit;
      FN_AND:  y = a_bit & b_bit;
      FN_OR:   y = a_bit | b_bit;
      FN_XOR:  y = a_bit ^ b_bit;
      FN_NAND: y = ~(a_bit & b_bit);
      FN_NOR:  y = ~(a_bit | b_bit);
      FN_XNOR: y = ~(a_bit ^ b_bit);
      FN_ONE:  y = 1'b1;
      default: y = 1'b0;
    endcase
    bad = code_bad
        | (uses_a && (src_a >= own_idx))
        | (uses_b && (src_b >= own_idx));
  end
endmodule

// File: rtl/genome_value_store.sv
`timescale 1ns/1ps
module genome_value_store
  import genome_pkg::*;
#(
  parameter int N_IN  = 16,
  parameter int NODES = 64,
  parameter int N_OUT = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [N_IN-1:0]             in_bits,
  input  logic                        we,
  input  logic [IDX_W-1:0]            widx,
  input  logic                        wbit,
  input  logic [IDX_W-1:0]            ra,
  input  logic [IDX_W-1:0]            rb,
  output logic                        a_bit,
  output logic                        b_bit,
  input  logic [N_OUT-1:0][IDX_W-1:0] sel,
  output logic [N_OUT-1:0]            gathered
);
  localparam int BASE  = 2 + N_IN;
  localparam int TOTAL = BASE + NODES;

  logic [TOTAL-1:0] vals;

  function automatic logic rd(input logic [IDX_W-1:0] idx);
    if (idx == IDX_W'(0))          return 1'b0;
    else if (idx == IDX_W'(1))     return 1'b1;
    else if (32'(idx) < TOTAL)     return vals[idx];
    else                           return 1'b0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vals <= TOTAL'(2'b10);
    end else begin
      if (load) begin
        vals[1:0]      <= 2'b10;
        vals[BASE-1:2] <= in_bits;
      end
      if (we && (32'(widx) >= BASE) && (32'(widx) < TOTAL)) begin
        vals[widx] <= wbit;
      end
    end
  end

  assign a_bit = rd(ra);
  assign b_bit = rd(rb);

  for (genvar k = 0; k < N_OUT; k++) begin : g_gather
    assign gathered[k] = rd(sel[k]);
  end
endmodule

// File: rtl/genome_eval.sv
`timescale 1ns/1ps
module genome_eval
  import genome_pkg::*;
#(
  parameter int A_W   = 8,
  parameter int B_W   = 8,
  parameter int NODES = 64,
  parameter int N_OUT = 16,
  localparam int NODE_AW = $clog2(NODES),
  localparam int CNT_W   = $clog2(NODES + 1),
  localparam int OUT_AW  = $clog2(N_OUT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gene_valid,
  output logic               gene_ready,
  input  logic [NODE_AW-1:0] gene_addr,
  input  logic [IDX_W-1:0]   gene_src_a,
  input  logic [IDX_W-1:0]   gene_src_b,
  input  logic [FN_W-1:0]    gene_fn,
  input  logic               osel_valid,
  output logic               osel_ready,
  input  logic [OUT_AW-1:0]  osel_addr,
  input  logic [IDX_W-1:0]   osel_idx,
  input  logic [CNT_W-1:0]   node_count,
  input  logic               start,
  input  logic [A_W-1:0]     opnd_a,
  input  logic [B_W-1:0]     opnd_b,
  output logic               done,
  output logic               err,
  output logic [N_OUT-1:0]   result
);
  localparam int N_IN  = A_W + B_W;
  localparam int BASE  = 2 + N_IN;
  localparam int TOTAL = BASE + NODES;

  if (TOTAL > (1 << IDX_W)) begin : g_idx_too_narrow
    $error("value space does not fit the index width");
  end

  eval_state_e             state_q;
  logic [CNT_W-1:0]        ptr_q;
  logic [CNT_W-1:0]        cnt_q;
  logic                    err_acc_q;
  logic                    done_q;
  logic                    err_q;
  logic [N_OUT-1:0]        result_q;

  logic                    idle;
  logic                    accept_start;
  logic                    oversize;
  logic                    last_node;
  logic                    node_we;
  gene_t                   gene_wdata;
  gene_t                   cur_gene;
  logic [IDX_W-1:0]        own_idx;
  logic                    a_bit, b_bit;
  logic                    node_y, node_bad;
  logic [N_OUT-1:0][IDX_W-1:0] sel;
  logic [N_OUT-1:0]        gathered;
  logic                    osel_bad;
  logic                    final_err;

  assign idle         = (state_q == ST_IDLE);
  assign accept_start = idle && start;
  assign oversize     = (32'(node_count) > NODES);
  assign last_node    = (ptr_q == cnt_q - 1'b1);
  assign node_we      = (state_q == ST_RUN);
  assign own_idx      = IDX_W'(BASE) + IDX_W'(ptr_q);
  assign gene_wdata   = '{src_a: gene_src_a, src_b: gene_src_b, fn: gene_fn};

  genome_gene_store #(.NODES(NODES), .AW(NODE_AW)) u_genes (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (gene_valid && idle),
    .waddr (gene_addr),
    .wdata (gene_wdata),
    .raddr (ptr_q[NODE_AW-1:0]),
    .rdata (cur_gene)
  );

  genome_outsel_store #(.N_OUT(N_OUT), .AW(OUT_AW)) u_outsel (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (osel_valid && idle),
    .waddr (osel_addr),
    .widx  (osel_idx),
    .sel   (sel)
  );

  genome_value_store #(.N_IN(N_IN), .NODES(NODES), .N_OUT(N_OUT)) u_vals (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_start),
    .in_bits  ({opnd_b, opnd_a}),
    .we       (node_we),
    .widx     (own_idx),
    .wbit     (node_y),
    .ra       (cur_gene.src_a),
    .rb       (cur_gene.src_b),
    .a_bit    (a_bit),
    .b_bit    (b_bit),
    .sel      (sel),
    .gathered (gathered)
  );

  genome_node_alu u_alu (
    .fn      (cur_gene.fn),
    .src_a   (cur_gene.src_a),
    .src_b   (cur_gene.src_b),
    .own_idx (own_idx),
    .a_bit   (a_bit),
    .b_bit   (b_bit),
    .y       (node_y),
    .bad     (node_bad)
  );

  // an output entry is legal only below the first undefined node slot
  always_comb begin
    osel_bad = 1'b0;
    for (int k = 0; k < N_OUT; k++) begin
      if (32'(sel[k]) >= BASE + 32'(cnt_q)) osel_bad = 1'b1;
    end
  end

  assign final_err = err_acc_q | osel_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ptr_q     <= '0;
      cnt_q     <= '0;
      err_acc_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      result_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            ptr_q     <= '0;
            cnt_q     <= node_count;
            err_acc_q <= oversize;
            state_q   <= (oversize || (node_count == '0)) ? ST_GATHER : ST_RUN;
          end
        end
        ST_RUN: begin
          err_acc_q <= err_acc_q | node_bad;
          ptr_q     <= ptr_q + 1'b1;
          if (last_node) state_q <= ST_GATHER;
        end
        ST_GATHER: begin
          done_q  <= 1'b1;
          err_q   <= final_err;
          if (!final_err) result_q <= gathered;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign gene_ready = idle;
  assign osel_ready = idle;
  assign done       = done_q;
  assign err        = err_q;
  assign result     = result_q;
endmodule

// File: rtl/genome_eval_chk.sv
`timescale 1ns/1ps
module genome_eval_chk #(
  parameter int RES_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             gene_ready,
  input logic             done,
  input logic             err,
  input logic [RES_W-1:0] result
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && gene_ready) |=> !gene_ready);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> gene_ready);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(err));

  // R7
  err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> $stable(result));
endmodule

bind genome_eval genome_eval_chk #(.RES_W($bits(result))) u_chk (.*);

// File: tb/genome_eval_test.sv
`timescale 1ns/1ps
module genome_eval_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gene_valid = 1'b0, gene_ready;
  logic [5:0] gene_addr = '0;
  logic [6:0] gene_src_a = '0, gene_src_b = '0;
  logic [3:0] gene_fn = '0;
  logic       osel_valid = 1'b0, osel_ready;
  logic [3:0] osel_addr = '0;
  logic [6:0] osel_idx = '0;
  logic [6:0] node_count = '0;
  logic       start = 1'b0;
  logic [7:0] opnd_a = '0, opnd_b = '0;
  logic       done, err;
  logic [15:0] result;

  always #5 clk = ~clk;

  genome_eval uut (
    .clk(clk), .rst_n(rst_n),
    .gene_valid(gene_valid), .gene_ready(gene_ready), .gene_addr(gene_addr),
    .gene_src_a(gene_src_a), .gene_src_b(gene_src_b), .gene_fn(gene_fn),
    .osel_valid(osel_valid), .osel_ready(osel_ready), .osel_addr(osel_addr),
    .osel_idx(osel_idx), .node_count(node_count), .start(start),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .done(done), .err(err), .result(result)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  bit [6:0] m_a [64];
  bit [6:0] m_b [64];
  bit [3:0] m_f [64];
  bit [6:0] m_o [16];
  bit [15:0] last_r = '0;

  typedef struct {
    bit        e;
    bit [15:0] r;
    string     tag;
  } exp_t;
  exp_t exp_q [$];

  task automatic check(bit ok, string tag, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // reference model built from the requirements
  function automatic void model(int cnt, bit [7:0] a, bit [7:0] b,
                                output bit e, output bit [15:0] r);
    bit v [128];
    for (int i = 0; i < 128; i++) v[i] = 1'b0;
    v[1] = 1'b1;
    for (int i = 0; i < 8; i++) begin
      v[2+i]  = a[i];
      v[10+i] = b[i];
    end
    e = (cnt > 64);
    if (!e) begin
      for (int n = 0; n < cnt; n++) begin
        int own = 18 + n;
        int f = int'(m_f[n]);
        bit x = v[m_a[n]];
        bit y = v[m_b[n]];
        bit o;
        if (f <= 7 && int'(m_a[n]) >= own) e = 1'b1;
        if (f >= 2 && f <= 7 && int'(m_b[n]) >= own) e = 1'b1;
        case (f)
          0: o = x;
          1: o = !x;
          2: o = x & y;
          3: o = x | y;
          4: o = x ^ y;
          5: o = !(x & y);
          6: o = !(x | y);
          7: o = !(x ^ y);
          8: o = 1'b1;
          9: o = 1'b0;
          default: begin o = 1'b0; e = 1'b1; end
        endcase
        v[own] = o;
      end
    end
    for (int k = 0; k < 16; k++) begin
      if (int'(m_o[k]) >= 18 + cnt) e = 1'b1;
      r[k] = v[m_o[k]];
    end
  endfunction

  task automatic put_gene(int n, int sa, int sb, int f);
    @(negedge clk);
    gene_valid = 1'b1; gene_addr = 6'(n);
    gene_src_a = 7'(sa); gene_src_b = 7'(sb); gene_fn = 4'(f);
    @(negedge clk);
    gene_valid = 1'b0;
    m_a[n] = 7'(sa); m_b[n] = 7'(sb); m_f[n] = 4'(f);
  endtask

  task automatic put_sel(int k, int idx);
    @(negedge clk);
    osel_valid = 1'b1; osel_addr = 4'(k); osel_idx = 7'(idx);
    @(negedge clk);
    osel_valid = 1'b0;
    m_o[k] = 7'(idx);
  endtask

  // driver: pushes the expected item, runs one evaluation, checks timing
  task automatic run(int cnt, bit [7:0] a, bit [7:0] b, string tag, bit poke = 1'b0);
    exp_t x;
    bit e;
    bit [15:0] r;
    int lat = 0;
    int nodes = (cnt > 64) ? 0 : cnt;
    model(cnt, a, b, e, r);
    x.e = e;
    x.r = e ? last_r : r;
    if (!e) last_r = r;
    x.tag = tag;
    exp_q.push_back(x);
    @(negedge clk);
    node_count = 7'(cnt); opnd_a = a; opnd_b = b; start = 1'b1;
    do begin
      @(negedge clk);
      lat++;
      start = 1'b0;
      if (lat == 1) begin
        check(!gene_ready && !osel_ready, "R9", "ready low while busy",
              int'({gene_ready, osel_ready}), 0);
        if (poke) begin
          start = 1'b1;
          gene_valid = 1'b1; gene_addr = '0; gene_fn = 4'd12;
          gene_src_a = '0; gene_src_b = '0;
          osel_valid = 1'b1; osel_addr = '0; osel_idx = 7'd127;
        end
      end else if (lat == 2) begin
        gene_valid = 1'b0; osel_valid = 1'b0;
      end
    end while (!done && lat < 500);
    check(lat == nodes + 2, "R8", "done latency", lat, nodes + 2);
  endtask

  // monitor: pops the scoreboard on every done pulse
  always @(negedge clk) begin
    exp_t x;
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "done with nothing expected", 1, 0);
      end else begin
        x = exp_q.pop_front();
        check(err == x.e, x.tag, "err flag", int'(err), int'(x.e));
        check(result == x.r, x.tag, "result", int'(result), int'(x.r));
      end
    end
  end

  task automatic load_adder();
    put_gene(0, 2, 10, 4);   // s0 = a0 ^ b0      -> 18
    put_gene(1, 2, 10, 2);   // c0 = a0 & b0      -> 19
    put_gene(2, 3, 11, 4);   // x1 = a1 ^ b1      -> 20
    put_gene(3, 20, 19, 4);  // s1 = x1 ^ c0      -> 21
    put_gene(4, 20, 19, 2);  // t  = x1 & c0      -> 22
    put_gene(5, 3, 11, 2);   // u  = a1 & b1      -> 23
    put_gene(6, 22, 23, 3);  // c1 = t | u        -> 24
    for (int k = 0; k < 16; k++) put_sel(k, 0);
    put_sel(0, 18); put_sel(1, 21); put_sel(2, 24);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m_a[i] = '0; m_b[i] = '0; m_f[i] = '0; end
    for (int k = 0; k < 16; k++) m_o[k] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(done == 1'b0, "R10", "done after reset", int'(done), 0);
    check(err == 1'b0, "R10", "err after reset", int'(err), 0);
    check(result == 16'h0, "R10", "result after reset", int'(result), 0);
    check(gene_ready && osel_ready, "R10", "ready after reset",
          int'({gene_ready, osel_ready}), 3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: constants only
    for (int k = 0; k < 16; k++) put_sel(k, k % 2);
    run(0, 8'h5A, 8'hC3, "R1 constants");

    // R2: operand bits straight through
    for (int k = 0; k < 16; k++) put_sel(k, 2 + k);
    run(0, 8'h81, 8'h7E, "R2 input order");
    run(0, 8'h3C, 8'h01, "R2 input order");

    // R3: every function code on a0, b0
    for (int n = 0; n < 10; n++) put_gene(n, 2, 10, n);
    for (int k = 0; k < 16; k++) put_sel(k, (k < 10) ? 18 + k : 0);
    for (int c = 0; c < 4; c++) run(10, 8'(c & 1), 8'(c >> 1), "R3 function codes");

    // R4: ignored sources may hold any index
    put_gene(0, 2, 127, 0);
    put_gene(1, 127, 127, 8);
    put_gene(2, 127, 126, 9);
    put_gene(3, 5, 120, 1);
    for (int k = 0; k < 16; k++) put_sel(k, (k < 4) ? 18 + k : 1);
    run(4, 8'h01, 8'h00, "R4 ignored sources");
    run(4, 8'h08, 8'hFF, "R4 ignored sources");

    // R6: two-bit adder, all operand pairs
    load_adder();
    for (int c = 0; c < 16; c++)
      run(7, 8'((c & 3) | 8'hA4), 8'((c >> 2) | 8'h58), "R6 adder");

    // R9: start and config writes while busy are dropped
    run(7, 8'h03, 8'h02, "R9 busy poke", 1'b1);
    run(7, 8'h01, 8'h03, "R9 after poke");

    // R5: backward-source violations
    put_gene(0, 2, 18, 2);
    run(7, 8'h02, 8'h01, "R5 src_b at own index");
    put_gene(0, 19, 10, 0);
    run(7, 8'h02, 8'h01, "R5 src_a above own index");
    put_gene(0, 2, 10, 4);

    // R7: bad code, undefined output slot, oversized count
    put_gene(1, 2, 10, 10);
    run(7, 8'h03, 8'h03, "R7 code above 9");
    put_gene(1, 2, 10, 2);
    put_sel(3, 25);
    run(7, 8'h03, 8'h03, "R7 undefined output slot");
    put_sel(3, 0);
    run(65, 8'h03, 8'h03, "R7 count too large");
    run(7, 8'h02, 8'h03, "R10 recovery after error");

    // R6: random legal genomes
    for (int g = 0; g < 25; g++) begin
      int cnt = 1 + int'($urandom_range(63));
      for (int n = 0; n < cnt; n++) begin
        int own = 18 + n;
        put_gene(n, int'($urandom_range(own - 1)), int'($urandom_range(own - 1)),
                 int'($urandom_range(9)));
      end
      for (int k = 0; k < 16; k++) put_sel(k, int'($urandom_range(17 + cnt)));
      for (int t = 0; t < 3; t++)
        run(cnt, 8'($urandom), 8'($urandom), "R6 random genome");
    end

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R8", "all results observed", exp_q.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule